// File: doc/BRIEF.md
# Serializer PHY Power Sequencer

This block brings a TMDS serializer PHY up and takes it down again, with no software stepping through the sequence. A power-up request arrives with the pixel clock rate as an unsigned integer in Hz. The sequencer picks PLL divider codes for that rate and programs the PLL. It waits for the lock input, with a bounded wait. It then programs the serializer configuration, current-control and calibration registers. A power-down request disables the serializer outputs and the PLL, then confirms that lock has dropped.

All register traffic leaves on a one-cycle write strobe with an address and a data word. The lock indication is a single input. Completion is signalled by a one-cycle done pulse or a one-cycle error pulse.

Top module: `phy_seq_ctrl`

## Requirements
- R1: The PLL word holds the enable in bit 0, the feedback multiplier 40 in bits 15:8, the input divider in bits 23:16 and the output divider code in bits 25:24. The output code means divide by 1, 2, 4 or 8 for the values 0 to 3. The five bands, from low to high, use input dividers 1, 2, 4, 8, 16 and output codes 3, 3, 2, 1, 0.
- R2: Each band includes its lower edge and excludes its upper edge. The edges are 0, 20 000 000, 42 500 000, 85 000 000, 170 000 000 and 340 000 000 Hz.
- R3: A power-up rate of 340 000 000 Hz or more produces an error pulse, and no write is issued.
- R4: A power-up writes the PLL word with enable set at address PLL_ADDR. It then waits for lock. After lock it writes the configuration word to CFG_ADDR, zero to ICTL_ADDR and zero to CAL_ADDR, in that order, each as a one-cycle strobe. A done pulse follows.
- R5: The configuration word always sets bits 0, 16, 18 and 19. Bit 24 is also set when the rate is strictly above 165 000 000 Hz.
- R6: For rates from 250 000 000 to 300 000 000 Hz inclusive, the value 0x1110 is ORed into the configuration word. Before the OR, bits 0, 1, 16 to 19 and 24 are cleared from that value. No extra value is added at other rates.
- R7: If lock stays low for TIMEOUT_CYCLES cycles after the PLL write, power-up ends with an error pulse. No configuration, current or calibration write is issued.
- R8: A power-down writes 0x000C0000 to CFG_ADDR, then 0 to PLL_ADDR. It waits for lock to fall and ends with a done pulse. If lock is still high after TIMEOUT_CYCLES cycles, it ends with an error pulse instead.
- R9: Power-up and power-down requests that arrive while a sequence is running are ignored.
- R10: After reset the block is idle, with no strobe, done or error. Done and error are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Power-up request, sampled when idle |
| stop_req | input | 1 | Power-down request, sampled when idle; power-up wins if both are high |
| pix_freq_hz | input | 32 | Pixel clock rate in Hz, sampled with start_req |
| pll_locked | input | 1 | PLL lock status |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | 32 | Register write data |
| seq_done | output | 1 | One-cycle pulse when a sequence succeeds |
| seq_err | output | 1 | One-cycle pulse when a sequence fails |

## Verification
The bench drives rates one below and exactly on every band edge. A design with closed intervals would pick the wrong divider at an edge, and one with a wrong comparison would drop 339 999 999 Hz or accept 340 000 000 Hz. It probes 165 000 000 and 165 000 001 Hz, and both ends of the 250 to 300 MHz window, where an off-by-one compare misplaces the termination or extra bits. A lock model that can freeze shows whether a stalled PLL ends in an error instead of a hang or a late configuration write. Requests injected mid-sequence show whether a careless design restarts or leaks extra writes.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int NUM_BANDS = 5;

    localparam logic [31:0] BAND_LO [NUM_BANDS] = '{32'd0, 32'd20_000_000, 32'd42_500_000,
                                                    32'd85_000_000, 32'd170_000_000};
    localparam logic [31:0] BAND_HI [NUM_BANDS] = '{32'd20_000_000, 32'd42_500_000, 32'd85_000_000,
                                                    32'd170_000_000, 32'd340_000_000};
    localparam logic [7:0]  BAND_IDF [NUM_BANDS] = '{8'd1, 8'd2, 8'd4, 8'd8, 8'd16};
    localparam logic [1:0]  BAND_ODF [NUM_BANDS] = '{2'd3, 2'd3, 2'd2, 2'd1, 2'd0};

    localparam logic [7:0]  FB_MULT       = 8'd40;
    localparam logic [31:0] CFG_BASE      = 32'h000D_0001;   // enable, ext data, sink det, bias det
    localparam logic [31:0] CFG_SRC_TERM  = 32'h0100_0000;
    localparam logic [31:0] CFG_RESERVED  = 32'h010F_0003;
    localparam logic [31:0] CFG_OFF_WORD  = 32'h000C_0000;
    localparam logic [31:0] TERM_ABOVE_HZ = 32'd165_000_000;
    localparam logic [31:0] BOOST_LO_HZ   = 32'd250_000_000;
    localparam logic [31:0] BOOST_HI_HZ   = 32'd300_000_000;
    localparam logic [31:0] BOOST_VALUE   = 32'h0000_1110;

    typedef struct packed {
        logic       valid;
        logic [7:0] idf;
        logic [1:0] odf;
    } band_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PLL, ST_LOCK, ST_CFG, ST_ICTL, ST_CAL,
        ST_OFF_CFG, ST_OFF_PLL, ST_UNLOCK, ST_OK, ST_FAIL
    } seq_state_t;

    function automatic logic [31:0] pll_word(band_t b);
        return {6'd0, b.odf, b.idf, FB_MULT, 7'd0, 1'b1};
    endfunction

    function automatic logic [31:0] cfg_word(logic [31:0] freq);
        logic [31:0] w;
        w = CFG_BASE;
        if (freq > TERM_ABOVE_HZ)
            w = w | CFG_SRC_TERM;
        if (freq >= BOOST_LO_HZ && freq <= BOOST_HI_HZ)
            w = w | (BOOST_VALUE & ~CFG_RESERVED);
        return w;
    endfunction

endpackage

// File: rtl/phy_band_sel.sv
module phy_band_sel
    import phy_seq_pkg::*;
(
    input  logic [31:0]          freq,
    output band_t                band,
    output logic [NUM_BANDS-1:0] hits
);
    for (genvar i = 0; i < NUM_BANDS; i++) begin : g_band
        assign hits[i] = (freq >= BAND_LO[i]) && (freq < BAND_HI[i]);
    end

    always_comb begin
        band = '0;
        for (int i = NUM_BANDS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                band.valid = 1'b1;
                band.idf   = BAND_IDF[i];
                band.odf   = BAND_ODF[i];
            end
        end
    end
endmodule

// File: rtl/phy_wait_timer.sv
module phy_wait_timer #(
    parameter int LIMIT = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
    import phy_seq_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int TIMEOUT_CYCLES = 5_000_000,
    parameter logic [ADDR_W-1:0] PLL_ADDR  = 12'h510,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h504,
    parameter logic [ADDR_W-1:0] ICTL_ADDR = 12'h518,
    parameter logic [ADDR_W-1:0] CAL_ADDR  = 12'h520
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic [31:0]       pix_freq_hz,
    input  logic              pll_locked,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              seq_done,
    output logic              seq_err
);
    seq_state_t state_q, state_d;
    logic [31:0] freq_q, freq_sel;
    band_t band;
    logic [NUM_BANDS-1:0] band_hits;
    logic waiting, expired;

    assign freq_sel = (state_q == ST_IDLE) ? pix_freq_hz : freq_q;

    phy_band_sel u_band (
        .freq (freq_sel),
        .band (band),
        .hits (band_hits)
    );

    assign waiting = (state_q == ST_LOCK) || (state_q == ST_UNLOCK);

    phy_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .expired (expired)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (start_req)
                    state_d = band.valid ? ST_PLL : ST_FAIL;
                else if (stop_req)
                    state_d = ST_OFF_CFG;
            end
            ST_PLL:     state_d = ST_LOCK;
            ST_LOCK: begin
                if (pll_locked)   state_d = ST_CFG;
                else if (expired) state_d = ST_FAIL;
            end
            ST_CFG:     state_d = ST_ICTL;
            ST_ICTL:    state_d = ST_CAL;
            ST_CAL:     state_d = ST_OK;
            ST_OFF_CFG: state_d = ST_OFF_PLL;
            ST_OFF_PLL: state_d = ST_UNLOCK;
            ST_UNLOCK: begin
                if (!pll_locked)  state_d = ST_OK;
                else if (expired) state_d = ST_FAIL;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            freq_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_req)
                freq_q <= pix_freq_hz;
        end
    end

    always_comb begin
        wr_en   = 1'b1;
        wr_addr = '0;
        wr_data = '0;
        case (state_q)
            ST_PLL:     begin wr_addr = PLL_ADDR;  wr_data = pll_word(band); end
            ST_CFG:     begin wr_addr = CFG_ADDR;  wr_data = cfg_word(freq_q); end
            ST_ICTL:    wr_addr = ICTL_ADDR;
            ST_CAL:     wr_addr = CAL_ADDR;
            ST_OFF_CFG: begin wr_addr = CFG_ADDR;  wr_data = CFG_OFF_WORD; end
            ST_OFF_PLL: wr_addr = PLL_ADDR;
            default:    wr_en = 1'b0;
        endcase
    end

    assign seq_done = (state_q == ST_OK);
    assign seq_err  = (state_q == ST_FAIL);

    p_bands_disjoint_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(band_hits));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> !seq_err);
    p_done_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(seq_done && seq_err));
    p_cfg_after_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == CFG_ADDR && wr_data[0]) |-> $past(pll_locked));
    p_pll_off_after_cfg_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == PLL_ADDR && !wr_data[0])
            |-> $past(wr_en && wr_addr == CFG_ADDR && wr_data == CFG_OFF_WORD));
endmodule

// File: tb/phy_seq_ctrl_test.sv
module phy_seq_ctrl_test;
    localparam int TMO = 20;
    localparam logic [11:0] A_PLL = 12'h510, A_CFG = 12'h504, A_ICTL = 12'h518, A_CAL = 12'h520;

    // {rate, expected PLL word (0 = expect error), expected configuration word}
    localparam int NV = 18;
    localparam logic [95:0] VEC [NV] = '{
        {32'd0,          32'h0301_2801, 32'h000D_0001},
        {32'd19_999_999, 32'h0301_2801, 32'h000D_0001},
        {32'd20_000_000, 32'h0302_2801, 32'h000D_0001},
        {32'd42_499_999, 32'h0302_2801, 32'h000D_0001},
        {32'd42_500_000, 32'h0204_2801, 32'h000D_0001},
        {32'd84_999_999, 32'h0204_2801, 32'h000D_0001},
        {32'd85_000_000, 32'h0108_2801, 32'h000D_0001},
        {32'd165_000_000, 32'h0108_2801, 32'h000D_0001},
        {32'd165_000_001, 32'h0108_2801, 32'h010D_0001},
        {32'd169_999_999, 32'h0108_2801, 32'h010D_0001},
        {32'd170_000_000, 32'h0010_2801, 32'h010D_0001},
        {32'd249_999_999, 32'h0010_2801, 32'h010D_0001},
        {32'd250_000_000, 32'h0010_2801, 32'h010D_1111},
        {32'd300_000_000, 32'h0010_2801, 32'h010D_1111},
        {32'd300_000_001, 32'h0010_2801, 32'h010D_0001},
        {32'd339_999_999, 32'h0010_2801, 32'h010D_0001},
        {32'd340_000_000, 32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF,   32'h0000_0000, 32'h0000_0000}
    };

    logic clk = 0, rst = 1, start_req = 0, stop_req = 0, pll_locked;
    logic [31:0] pix_freq_hz = '0;
    logic wr_en, seq_done, seq_err;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;

    always #4 clk = ~clk;

    phy_seq_ctrl #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
        .pix_freq_hz(pix_freq_hz), .pll_locked(pll_locked),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .seq_done(seq_done), .seq_err(seq_err)
    );

    // PLL model: follows the enable bit of a PLL write after 3 cycles unless frozen
    logic stuck = 0, lk_target;
    int lk_cnt;
    always @(posedge clk) begin
        if (rst) begin
            pll_locked <= 1'b0; lk_cnt <= 0; lk_target <= 1'b0;
        end else if (wr_en && wr_addr == A_PLL) begin
            lk_target <= wr_data[0]; lk_cnt <= 3;
        end else if (lk_cnt > 0) begin
            lk_cnt <= lk_cnt - 1;
            if (lk_cnt == 1 && !stuck) pll_locked <= lk_target;
        end
    end

    // write and pulse monitor
    logic [11:0] la [8];
    logic [31:0] ld [8];
    int nwr, cnt_done, cnt_fail, n_chk, n_bad, cyc;
    always @(negedge clk) begin
        if (wr_en) begin
            if (nwr < 8) begin la[nwr] = wr_addr; ld[nwr] = wr_data; end
            nwr = nwr + 1;
        end
        if (seq_done) cnt_done = cnt_done + 1;
        if (seq_err)  cnt_fail = cnt_fail + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_end();
        int n = 0;
        while (cnt_done + cnt_fail == 0 && n < 200) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_log();
        nwr = 0; cnt_done = 0; cnt_fail = 0;
    endtask

    task automatic do_start(input logic [31:0] f);
        @(negedge clk); clear_log();
        start_req = 1; pix_freq_hz = f;
        @(negedge clk); start_req = 0;
        wait_end();
    endtask

    task automatic do_stop();
        @(negedge clk); clear_log();
        stop_req = 1;
        @(negedge clk); stop_req = 0;
        wait_end();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    initial begin
        nwr = 0; cnt_done = 0; cnt_fail = 0; n_chk = 0; n_bad = 0; cyc = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: idle after reset
        chk(!wr_en && !seq_done && !seq_err, "R10 reset idle",
            {29'd0, wr_en, seq_done, seq_err}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] f, ep, ec;
            {f, ep, ec} = VEC[i];
            do_start(f);
            if (ep == 0) begin
                chk(cnt_fail == 1 && cnt_done == 0 && nwr == 0, "R3 out of band",
                    32'(nwr), 32'd0);
            end else begin
                chk(nwr >= 1 && la[0] == A_PLL && ld[0] == ep, "R1 R2 PLL word", ld[0], ep);
                chk(nwr >= 2 && la[1] == A_CFG && ld[1] == ec, "R5 R6 config word", ld[1], ec);
                chk(nwr == 4 && la[2] == A_ICTL && ld[2] == 0 && la[3] == A_CAL && ld[3] == 0
                    && cnt_done == 1 && cnt_fail == 0, "R4 R10 start order",
                    32'(nwr), 32'd4);
                do_stop();
                chk(nwr == 2 && la[0] == A_CFG && ld[0] == 32'h000C_0000 && la[1] == A_PLL
                    && ld[1] == 0 && cnt_done == 1 && cnt_fail == 0, "R8 stop order",
                    ld[0], 32'h000C_0000);
            end
        end

        // R9: requests during a running power-up are ignored
        @(negedge clk); clear_log();
        start_req = 1; pix_freq_hz = 32'd100_000_000;
        @(negedge clk); start_req = 0;
        @(negedge clk);
        start_req = 1; stop_req = 1; pix_freq_hz = 32'd10_000_000;
        @(negedge clk); start_req = 0; stop_req = 0;
        wait_end();
        chk(nwr == 4 && ld[0] == 32'h0108_2801 && ld[1] == 32'h000D_0001 && cnt_done == 1,
            "R9 busy start ignored", ld[0], 32'h0108_2801);

        // R9: requests during a running power-down are ignored
        @(negedge clk); clear_log();
        stop_req = 1;
        @(negedge clk); stop_req = 0; start_req = 1; pix_freq_hz = 32'd50_000_000;
        @(negedge clk); start_req = 0;
        wait_end();
        chk(nwr == 2 && cnt_done == 1 && cnt_fail == 0, "R9 busy stop ignored",
            32'(nwr), 32'd2);

        // R7: lock never arrives
        stuck = 1;
        do_start(32'd74_250_000);
        chk(cnt_fail == 1 && cnt_done == 0 && nwr == 1 && la[0] == A_PLL, "R7 lock timeout",
            32'(nwr), 32'd1);
        stuck = 0;
        do_stop();
        chk(cnt_done == 1 && nwr == 2, "R8 stop after failed start", 32'(cnt_done), 32'd1);

        // R8: lock refuses to drop on power-down
        do_start(32'd148_500_000);
        chk(cnt_done == 1 && nwr == 4, "R4 start before stuck stop", 32'(nwr), 32'd4);
        stuck = 1;
        do_stop();
        chk(cnt_fail == 1 && cnt_done == 0 && nwr == 2, "R8 unlock timeout",
            32'(cnt_fail), 32'd1);
        chk(pll_locked == 1'b1, "R8 lock still high", {31'd0, pll_locked}, 32'd1);
        stuck = 0;

        // R10: reset during a sequence returns to idle
        @(negedge clk); clear_log();
        start_req = 1; pix_freq_hz = 32'd27_000_000;
        @(negedge clk); start_req = 0; rst = 1;
        @(negedge clk); rst = 0;
        repeat (TMO + 5) @(negedge clk);
        chk(nwr == 1 && cnt_done == 0 && cnt_fail == 0, "R10 reset aborts", 32'(nwr), 32'd1);

        summary();
    end
endmodule